// File: doc/BRIEF.md
# Quadrature Bus-Phase Clock Generator

This block derives two bus-phase clocks from a single faster master clock for a processor that expects its bus timing supplied from outside. The two outputs, `busQ` and `busE`, run at the same frequency with a 50% duty cycle. They stay in fixed quadrature: `busE` is `busQ` delayed by exactly one quarter of the bus period, so every rising edge of `busE` follows the rising edge of `busQ` that comes before it. A quarter-cycle lag is enough for processors that require the lead of Q over E to be at least one fifth of a bus cycle.

Each quarter phase lasts `QUARTER_CYCLES` master cycles, which gives a bus period of `4*QUARTER_CYCLES` master cycles. With the default of one master cycle per quarter, a 4 MHz master gives a 1 MHz bus. A larger value gives a slower bus from the same master clock. At elaboration the block reports an error if the bus rate that results would be below the configured floor. The default floor is 105 kHz. An optional one-cycle strobe, `quarterTick`, marks every quarter-phase boundary for logic that must act in step with the bus phases.

Top module: `qclk_gen`

## Requirements
- R1: While `rstN` is low, `busQ`, `busE` and `quarterTick` are all 0. Reset is asynchronous, so the outputs clear as soon as `rstN` falls, even in the middle of a master cycle.
- R2: After reset is released, the first output to rise is `busQ`. It rises on master rising edge number `QUARTER_CYCLES`, counting edges from the release, while `busE` is still 0.
- R3: The pair {E,Q} goes through the states 00, 01, 11, 10 and then back to 00. Each state is held for exactly `QUARTER_CYCLES` master cycles.
- R4: `busQ` and `busE` each have a period of `4*QUARTER_CYCLES` master cycles and a high time of `2*QUARTER_CYCLES` master cycles.
- R5: Each rising edge of `busE` comes exactly `QUARTER_CYCLES` master cycles after the last rising edge of `busQ`. When `busE` rises, `busQ` is high. When `busQ` rises, `busE` is low.
- R6: `quarterTick` is 1 in exactly those master cycles in which `busQ` or `busE` has just changed value, and 0 in all other cycles. When `QUARTER_CYCLES` is 1, it therefore stays at 1 from the first edge after reset onward.
- R7: At most one of `busQ` and `busE` changes on any master edge, and both are driven directly from flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busQ | output | 1 | Leading bus-phase clock |
| busE | output | 1 | Lagging bus-phase clock, a quarter period behind `busQ` |
| quarterTick | output | 1 | One-cycle strobe after each quarter-phase boundary |

## Verification
The hardest situation to reach from the ports is a reset that arrives partway through a quarter phase, between master edges. After it, the generator has to start again from the 00 state, and the first edge must still be on Q after a full quarter. The stimulus drops `rstN` a few nanoseconds after a master edge while the outputs are in the 11 state. It checks that the outputs have cleared before the next edge, then releases reset and measures the first Q rise and the Q-to-E lag once more. A second instance with one master cycle per quarter covers the case where a boundary occurs on every edge and the strobe never falls.

// File: rtl/qclk_pkg.sv
package qclk_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic advance;   // move to the next quarter phase on this edge
  } qclkStrobe_t;

  // Phase encoding: bit0 drives Q, bit1 drives E
  typedef logic [1:0] qclkPhase_t;

  localparam qclkPhase_t PHASE_IDLE = 2'b00;

  // Johnson successor: 00 -> 01 -> 11 -> 10 -> 00
  function automatic qclkPhase_t nextPhase(input qclkPhase_t cur);
    return {cur[0], ~cur[1]};
  endfunction

endpackage

// File: rtl/qclk_ctrl.sv
module qclk_ctrl
  import qclk_pkg::*;
#(
  parameter int QUARTER_CYCLES = 1
) (
  input  logic        clk,
  input  logic        rstN,
  output qclkStrobe_t strobes
);

  localparam int CNT_W = (QUARTER_CYCLES > 1) ? $clog2(QUARTER_CYCLES) : 1;

  generate
    if (QUARTER_CYCLES == 1) begin : g_every_edge
      // Every master edge ends a quarter
      assign strobes.advance = 1'b1;
    end else begin : g_counted
      localparam logic [CNT_W-1:0] LAST_COUNT = CNT_W'(QUARTER_CYCLES - 1);
      logic [CNT_W-1:0] quarterCnt;
      logic             atLast;

      assign atLast = (quarterCnt == LAST_COUNT);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          quarterCnt <= '0;
        end else if (atLast) begin
          quarterCnt <= '0;
        end else begin
          quarterCnt <= quarterCnt + 1'b1;
        end
      end

      assign strobes.advance = atLast;
    end
  endgenerate

endmodule

// File: rtl/qclk_dp.sv
module qclk_dp
  import qclk_pkg::*;
#(
  parameter bit ENABLE_TICK = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  qclkStrobe_t strobes,
  output logic        busQ,
  output logic        busE,
  output logic        quarterTick
);

  qclkPhase_t phaseReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseReg <= PHASE_IDLE;
    end else if (strobes.advance) begin
      phaseReg <= nextPhase(phaseReg);
    end
  end

  // Outputs come straight from the phase flops
  assign busQ = phaseReg[0];
  assign busE = phaseReg[1];

  generate
    if (ENABLE_TICK) begin : g_tick
      logic tickReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          tickReg <= 1'b0;
        end else begin
          tickReg <= strobes.advance;
        end
      end
      assign quarterTick = tickReg;
    end else begin : g_no_tick
      assign quarterTick = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/qclk_gen.sv
module qclk_gen
  import qclk_pkg::*;
#(
  parameter int QUARTER_CYCLES = 1,
  parameter int MASTER_HZ      = 4_000_000,
  parameter int MIN_BUS_HZ     = 105_000,
  parameter bit ENABLE_TICK    = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  output logic busQ,
  output logic busE,
  output logic quarterTick
);

  localparam int BUS_HZ = MASTER_HZ / (4 * QUARTER_CYCLES);

  // Configuration sanity at elaboration
  initial begin
    if (QUARTER_CYCLES < 1) begin
      $error("qclk_gen: QUARTER_CYCLES must be at least 1");
    end
    if (BUS_HZ < MIN_BUS_HZ) begin
      $error("qclk_gen: bus rate %0d Hz is below floor %0d Hz", BUS_HZ, MIN_BUS_HZ);
    end
  end

  qclkStrobe_t strobes;

  qclk_ctrl #(
    .QUARTER_CYCLES(QUARTER_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes)
  );

  qclk_dp #(
    .ENABLE_TICK(ENABLE_TICK)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .busQ       (busQ),
    .busE       (busE),
    .quarterTick(quarterTick)
  );

endmodule

// File: rtl/qclk_gen_chk.sv
module qclk_gen_chk #(
  parameter int QUARTER_CYCLES = 1,
  parameter bit ENABLE_TICK    = 1'b1
) (
  input logic clk,
  input logic rstN,
  input logic busQ,
  input logic busE,
  input logic quarterTick
);

  logic prevQ, prevE;
  logic chg;
  int   run;

  assign chg = (busQ != prevQ) || (busE != prevE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ <= 1'b0;
      prevE <= 1'b0;
      run   <= 0;
    end else begin
      prevQ <= busQ;
      prevE <= busE;
      run   <= chg ? 1 : run + 1;
    end
  end

  // R1: outputs quiet while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      a_r1_reset_quiet: assert (!busQ && !busE && !quarterTick);
    end
  end

  // R3: each state held exactly one quarter
  a_r3_quarter_len: assert property (@(posedge clk) disable iff (!rstN)
    chg |-> (run == QUARTER_CYCLES));
  a_r3_no_stretch: assert property (@(posedge clk) disable iff (!rstN)
    !chg |-> (run < QUARTER_CYCLES));
  // R3: Johnson order 00 -> 01 -> 11 -> 10
  a_r3_order: assert property (@(posedge clk) disable iff (!rstN)
    chg |-> ({busE, busQ} == {prevQ, ~prevE}));

  // R5: E rises only while Q is high; Q rises only while E is low
  a_r5_e_after_q: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busE) |-> busQ);
  a_r5_q_before_e: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busQ) |-> !busE);

  // R7: never both outputs switching together
  a_r7_single_edge: assert property (@(posedge clk) disable iff (!rstN)
    $countones({busQ ^ prevQ, busE ^ prevE}) <= 1);

  generate
    if (ENABLE_TICK) begin : g_tick_chk
      // R6: strobe marks exactly the cycles following a change
      a_r6_tick_on_change: assert property (@(posedge clk) disable iff (!rstN)
        chg |-> quarterTick);
      a_r6_tick_only_change: assert property (@(posedge clk) disable iff (!rstN)
        quarterTick |-> chg);
    end
  endgenerate

endmodule

bind qclk_gen qclk_gen_chk #(
  .QUARTER_CYCLES(QUARTER_CYCLES),
  .ENABLE_TICK   (ENABLE_TICK)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busQ       (busQ),
  .busE       (busE),
  .quarterTick(quarterTick)
);

// File: tb/qclk_gen_bench.sv
module qclk_gen_bench;

  localparam int QC_A = 3;
  localparam int QC_B = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic qA, eA, tA, qB, eB, tB;

  qclk_gen #(.QUARTER_CYCLES(QC_A), .MASTER_HZ(50_000_000)) u_qclk_gen (
    .clk(clk), .rstN(rstN), .busQ(qA), .busE(eA), .quarterTick(tA));

  qclk_gen #(.QUARTER_CYCLES(QC_B), .MASTER_HZ(50_000_000)) u_qclk_gen_fast (
    .clk(clk), .rstN(rstN), .busQ(qB), .busE(eB), .quarterTick(tB));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference: master edges since reset release
  int k;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) k <= 0;
    else       k <= k + 1;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int refQ(input int kk, input int qc);
    int ph = (kk / qc) % 4;
    return (ph == 1 || ph == 2) ? 1 : 0;
  endfunction
  function automatic int refE(input int kk, input int qc);
    int ph = (kk / qc) % 4;
    return (ph == 2 || ph == 3) ? 1 : 0;
  endfunction
  function automatic int refT(input int kk, input int qc);
    return (kk > 0 && (kk % qc) == 0) ? 1 : 0;
  endfunction

  // Cycle-by-cycle comparison and edge measurements on instance A
  logic pQ = 1'b0, pE = 1'b0;
  int lastQRise = -1, lastERise = -1, lastQFall = -1;
  bit firstSeen = 1'b0;

  always @(negedge clk) begin
    if (!done) begin
      if (!rstN) begin
        chk("R1", "Q in reset", qA, 0);
        chk("R1", "E in reset", eA, 0);
        chk("R1", "tick in reset", tA, 0);
        chk("R1", "fast Q in reset", qB, 0);
        lastQRise = -1; lastERise = -1; lastQFall = -1; firstSeen = 1'b0;
      end else begin
        chk("R3", "Q", qA, refQ(k, QC_A));
        chk("R3", "E", eA, refE(k, QC_A));
        chk("R6", "tick", tA, refT(k, QC_A));
        chk("R3", "fast Q", qB, refQ(k, QC_B));
        chk("R3", "fast E", eB, refE(k, QC_B));
        chk("R6", "fast tick", tB, refT(k, QC_B));
        if (qA && !pQ) begin
          if (!firstSeen) begin
            chk("R2", "first Q rise edge", k, QC_A);
            chk("R2", "E low at first Q rise", eA, 0);
            firstSeen = 1'b1;
          end
          if (lastQRise >= 0) chk("R4", "Q period", k - lastQRise, 4 * QC_A);
          lastQRise = k;
        end
        if (!qA && pQ) begin
          if (lastQRise >= 0) chk("R4", "Q high time", k - lastQRise, 2 * QC_A);
          lastQFall = k;
        end
        if (eA && !pE) begin
          chk("R5", "Q-to-E lag", k - lastQRise, QC_A);
          if (lastERise >= 0) chk("R4", "E period", k - lastERise, 4 * QC_A);
          lastERise = k;
        end
        if (!eA && pE) begin
          chk("R4", "E high time", k - lastERise, 2 * QC_A);
          chk("R5", "Q-fall-to-E-fall lag", k - lastQFall, QC_A);
        end
      end
      pQ = qA;
      pE = eA;
    end
  end

  task automatic finishRun();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Watchdog
  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at t=%0t", $time);
      finishRun();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;                        // R2: release, then run
    repeat (200) @(negedge clk);
    // Reach state 11 of instance A (quarter 2), then reset mid-cycle
    while (!(qA && eA)) @(negedge clk);
    @(posedge clk);
    #3;
    rstN = 1'b0;
    #1;
    chk("R1", "async Q clear", qA, 0);
    chk("R1", "async E clear", eA, 0);
    chk("R1", "async tick clear", tA, 0);
    chk("R1", "async fast Q clear", qB, 0);
    chk("R1", "async fast E clear", eB, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (150) @(negedge clk);
    chk("R2", "first Q rise seen after second release", firstSeen, 1);
    @(posedge clk);
    #5;
    finishRun();
  end

endmodule